// File: doc/BRIEF.md
# Slave Port Arbiter

This block decides which of up to sixteen bus masters owns a single slave port of a multi-master interconnect. Each master raises a request line. The arbiter answers with a registered one-hot grant, the encoded index of the granted master and a valid flag. Arbitration is either round-robin or fixed-priority, chosen by a configuration input. In fixed-priority mode each master carries a 4-bit priority.

A granted master keeps the port until its transfer reaches a boundary. A boundary is one of the following:
- a beat marked last;
- the configured beat limit of an undefined-length burst;
- the expiry of a per-port slot counter;
- the owner withdrawing its request.

When nobody requests, a parking policy decides the outcome. The port can be left ungranted, kept by the last owner, or handed to a configured master.

Every decision made from the inputs of one cycle shows on the grant outputs after the next rising clock edge. All configuration arrives on plain input ports.

Top module: `slave_port_arbiter`

## Requirements
- R1: While reset is active, grant is all zero, grant_valid is 0 and grant_id is 0.
- R2: grant has at most one bit set. grant_valid is 1 exactly when a bit is set, and grant_id is then that bit's index.
- R3: With arb_fixed = 1, arbitration grants the requester with the numerically largest 4-bit priority. Master m's priority is prio[4m+3:4m]. On a tie, the lowest master index wins.
- R4: With arb_fixed = 0, arbitration searches the request lines upward from the index after the most recently granted master, wrapping at the top. The first requester found is granted. After reset the search starts at master 1.
- R5: A requesting owner keeps the grant until a boundary. A higher-priority request arriving in the meantime does not take the grant away. A beat with beat_last = 1 is a boundary, and the arbitration result appears on the next cycle.
- R6: While burst_undef = 1, the owner's 3-bit field burst_lim[3m+2:3m] limits its beats. The codes are: 1 is one beat, 2 is four beats, 3 is eight beats and 4 is sixteen beats. On the limit beat, arbitration is forced. Code 0 and the reserved codes 5 to 7 set no limit.
- R7: With slot_max = N > 0, a requesting owner holds the port for at most N consecutive cycles before arbitration is forced. With slot_max = 0 there is no cap.
- R8: If the owner drops its request while another master requests, the grant passes to the arbitration winner on the next cycle.
- R9: With park_mode = 0, and also with the unused code 3, the grant falls to none on the cycle after no master requests.
- R10: With park_mode = 1 and no requests, the current grant is kept unchanged.
- R11: With park_mode = 2 and no requests, the grant goes to master park_id on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NM | Request line per master |
| beat | input | 1 | A beat of the owner's transfer completes this cycle |
| beat_last | input | 1 | The beat is the last of its burst |
| burst_undef | input | 1 | The owner's current burst has undefined length |
| arb_fixed | input | 1 | 1 selects fixed priority, 0 selects round-robin |
| park_mode | input | 2 | Idle policy: 0 none, 1 keep last, 2 fixed master |
| park_id | input | IDW | Master that owns an idle port when park_mode is 2 |
| prio | input | 4*NM | 4-bit priority per master |
| slot_max | input | SLOTW | Maximum consecutive hold cycles, 0 for no cap |
| burst_lim | input | 3*NM | Undefined-length burst limit code per master |
| grant | output | NM | One-hot grant |
| grant_id | output | IDW | Index of the granted master |
| grant_valid | output | 1 | A master is granted |

## Verification
The checker assumes that beat, beat_last and burst_undef describe only the current owner's transfer. It also assumes that configuration changes are applied between clock edges and not treated as transfer events. The stability property for held grants is therefore qualified by the absence of a beat and by a zero slot cap. The stimulus drives the beat inputs only while a requesting master holds the port, and it changes configuration only at section boundaries or on a cycle whose expected outcome accounts for the change. Reset is pulsed between sections, so each round-robin search starts from a known pointer.

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter #(
  parameter int NM    = 16,
  parameter int SLOTW = 8,
  localparam int IDW  = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req,
  input  logic             beat,
  input  logic             beat_last,
  input  logic             burst_undef,
  input  logic             arb_fixed,
  input  logic [1:0]       park_mode,
  input  logic [IDW-1:0]   park_id,
  input  logic [4*NM-1:0]  prio,
  input  logic [SLOTW-1:0] slot_max,
  input  logic [3*NM-1:0]  burst_lim,
  output logic [NM-1:0]    grant,
  output logic [IDW-1:0]   grant_id,
  output logic             grant_valid
);
  localparam int PW = 4;
  localparam int LW = 3;
  localparam int BW = 5;

  logic [IDW-1:0]   owner;
  logic             held;
  logic [BW-1:0]    beat_cnt;
  logic [SLOTW-1:0] slot_cnt;

  wire own_req = req[owner];
  wire active  = held && own_req;

  logic [LW-1:0] lim_code;
  logic [BW-1:0] lim_beats;
  assign lim_code = burst_lim[owner*LW +: LW];

  always_comb begin
    case (lim_code)
      3'd1:    lim_beats = BW'(1);
      3'd2:    lim_beats = BW'(4);
      3'd3:    lim_beats = BW'(8);
      3'd4:    lim_beats = BW'(16);
      default: lim_beats = '0;
    endcase
  end

  wire lim_hit  = beat && burst_undef && (lim_beats != '0) && (beat_cnt + BW'(1) == lim_beats);
  wire slot_hit = (slot_max != '0) && ({1'b0, slot_cnt} + (SLOTW+1)'(1) >= {1'b0, slot_max});
  wire rel      = active && ((beat && beat_last) || lim_hit || slot_hit);
  wire arb_now  = !active || rel;
  wire any_req  = |req;

  logic           rr_found;
  logic [IDW-1:0] rr_id;
  int             rr_idx;
  always_comb begin
    rr_found = 1'b0;
    rr_id    = '0;
    rr_idx   = 0;
    for (int i = 1; i <= NM; i++) begin
      rr_idx = (int'(owner) + i) % NM;
      if (!rr_found && req[rr_idx]) begin
        rr_found = 1'b1;
        rr_id    = IDW'(rr_idx);
      end
    end
  end

  logic           fp_found;
  logic [IDW-1:0] fp_id;
  logic [PW-1:0]  fp_p;
  always_comb begin
    fp_found = 1'b0;
    fp_id    = '0;
    fp_p     = '0;
    for (int i = 0; i < NM; i++) begin
      if (req[i] && (!fp_found || prio[i*PW +: PW] > fp_p)) begin
        fp_found = 1'b1;
        fp_id    = IDW'(i);
        fp_p     = prio[i*PW +: PW];
      end
    end
  end

  logic           nxt_held;
  logic [IDW-1:0] nxt_owner;
  always_comb begin
    nxt_held  = held;
    nxt_owner = owner;
    if (arb_now) begin
      if (any_req) begin
        nxt_held  = 1'b1;
        nxt_owner = arb_fixed ? fp_id : rr_id;
      end else begin
        case (park_mode)
          2'd1:    nxt_held = held;
          2'd2:    begin nxt_held = 1'b1; nxt_owner = park_id; end
          default: nxt_held = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      owner    <= '0;
      beat_cnt <= '0;
      slot_cnt <= '0;
    end else begin
      held  <= nxt_held;
      owner <= nxt_owner;
      if (arb_now) begin
        beat_cnt <= '0;
        slot_cnt <= '0;
      end else begin
        slot_cnt <= slot_cnt + SLOTW'(1);
        if (beat && burst_undef) beat_cnt <= beat_cnt + BW'(1);
      end
    end
  end

  assign grant       = held ? (NM'(1) << owner) : '0;
  assign grant_id    = held ? owner : '0;
  assign grant_valid = held;
endmodule

// File: rtl/slave_port_arbiter_chk.sv
module slave_port_arbiter_chk #(
  parameter int NM    = 16,
  parameter int SLOTW = 8,
  localparam int IDW  = (NM > 1) ? $clog2(NM) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    req,
  input logic             beat,
  input logic [1:0]       park_mode,
  input logic [IDW-1:0]   park_id,
  input logic [SLOTW-1:0] slot_max,
  input logic [NM-1:0]    grant,
  input logic [IDW-1:0]   grant_id,
  input logic             grant_valid
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  // R2
  grant_id_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant[grant_id]);

  // R5
  hold_until_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && req[grant_id] && !beat && slot_max == '0) |=> $stable(grant));

  // R9
  park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req) && (park_mode == 2'd0 || park_mode == 2'd3)) |=> !grant_valid);

  // R10
  park_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req) && park_mode == 2'd1) |=> $stable(grant));

  // R11
  park_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req) && park_mode == 2'd2) |=> (grant_valid && grant_id == $past(park_id)));
endmodule

bind slave_port_arbiter slave_port_arbiter_chk #(.NM(NM), .SLOTW(SLOTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .beat(beat), .park_mode(park_mode),
  .park_id(park_id), .slot_max(slot_max), .grant(grant), .grant_id(grant_id),
  .grant_valid(grant_valid)
);

// File: tb/sim_slave_port_arbiter.sv
`timescale 1ns/1ps
module sim_slave_port_arbiter;
  localparam int NM = 16;
  localparam int SLOTW = 8;
  localparam int IDW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [NM-1:0]    req = '0;
  logic             beat = 1'b0, beat_last = 1'b0, burst_undef = 1'b0;
  logic             arb_fixed = 1'b1;
  logic [1:0]       park_mode = 2'd0;
  logic [IDW-1:0]   park_id = '0;
  logic [4*NM-1:0]  prio = '0;
  logic [SLOTW-1:0] slot_max = '0;
  logic [3*NM-1:0]  burst_lim = '0;
  logic [NM-1:0]    grant;
  logic [IDW-1:0]   grant_id;
  logic             grant_valid;

  slave_port_arbiter #(.NM(NM), .SLOTW(SLOTW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .beat(beat), .beat_last(beat_last),
    .burst_undef(burst_undef), .arb_fixed(arb_fixed), .park_mode(park_mode),
    .park_id(park_id), .prio(prio), .slot_max(slot_max), .burst_lim(burst_lim),
    .grant(grant), .grant_id(grant_id), .grant_valid(grant_valid)
  );

  typedef struct { logic v; logic [IDW-1:0] id; string tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check_now(logic v, logic [IDW-1:0] id, string tag);
    logic [NM-1:0] oh;
    oh = v ? (NM'(1) << id) : '0;
    n_chk++;
    if (grant_valid !== v || grant !== oh || (v && grant_id !== id)) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b id=%0d grant=%h, expected valid=%0b id=%0d grant=%h",
               tag, grant_valid, grant_id, grant, v, id, oh);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check_now(e.v, e.id, e.tag);
    end
  end

  task automatic tick(logic v, logic [IDW-1:0] id, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.v = v; e.id = id; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; beat = 0; beat_last = 0; burst_undef = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_now(1'b0, '0, "R1 reset state");
    rst_n = 1'b1;
  endtask

  function automatic void set_prio(int m, int p);
    prio[m*4 +: 4] = 4'(p);
  endfunction

  function automatic void set_lim(int m, int c);
    burst_lim[m*3 +: 3] = 3'(c);
  endfunction

  function automatic logic [NM-1:0] rq(int a, int b = -1, int c = -1, int d = -1);
    logic [NM-1:0] r;
    r = '0;
    r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    if (d >= 0) r[d] = 1'b1;
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected test completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R3 and R5: fixed priority with a tie, then holding the grant
    arb_fixed = 1; set_prio(3, 2); set_prio(5, 7); set_prio(9, 7); set_prio(1, 15);
    req = rq(3, 5, 9);
    tick(1, 5, "R3 tie to lowest id");
    tick(1, 5, "R5 hold while requesting");
    req = rq(1, 3, 5, 9);
    tick(1, 5, "R5 higher priority waits");
    beat = 1; beat_last = 1;
    tick(1, 1, "R3 highest priority after last beat");
    beat = 0; beat_last = 0;
    req = rq(3, 5, 9);
    tick(1, 5, "R8 owner drop rearbitrates");
    req = '0;
    tick(0, 0, "R9 no default master");

    // R4 round robin
    do_reset();
    arb_fixed = 0;
    req = rq(2, 9, 12);
    tick(1, 2, "R4 first search from 1");
    beat = 1; beat_last = 1;
    tick(1, 9, "R4 next after 2");
    tick(1, 12, "R4 next after 9");
    tick(1, 2, "R4 wrap after 12");
    beat = 0; beat_last = 0;
    req = '0; park_mode = 2'd3;
    tick(0, 0, "R9 unused park code acts as none");
    park_mode = 2'd0;

    // R6 undefined-length burst limits
    do_reset();
    arb_fixed = 0; set_lim(4, 2); set_lim(6, 0);
    req = rq(4, 6); burst_undef = 1;
    tick(1, 4, "R6 grant 4");
    beat = 1;
    for (int k = 0; k < 3; k++) tick(1, 4, "R6 four-beat limit not reached");
    tick(1, 6, "R6 four-beat limit forces rearbitration");
    for (int k = 0; k < 17; k++) tick(1, 6, "R6 code 0 no limit");
    set_lim(6, 5);
    for (int k = 0; k < 17; k++) tick(1, 6, "R6 reserved code 5 no limit");
    beat_last = 1;
    tick(1, 4, "R5 last beat releases to 4");
    beat_last = 0; set_lim(4, 1);
    tick(1, 6, "R6 single-beat limit");
    beat = 0; burst_undef = 0;

    // R7 slot cycle cap
    do_reset();
    arb_fixed = 0; slot_max = 8'd3;
    req = rq(1, 2);
    tick(1, 1, "R7 grant 1");
    tick(1, 1, "R7 hold cycle 2");
    tick(1, 1, "R7 hold cycle 3");
    tick(1, 2, "R7 slot expired");
    slot_max = 8'd0;
    for (int k = 0; k < 10; k++) tick(1, 2, "R7 no cap when zero");

    // R10 and R11 parking policies
    do_reset();
    arb_fixed = 1; park_mode = 2'd1;
    req = rq(7);
    tick(1, 7, "R10 grant 7");
    req = '0;
    for (int k = 0; k < 3; k++) tick(1, 7, "R10 last master kept");
    park_mode = 2'd2; park_id = 4'd11;
    tick(1, 11, "R11 fixed park master");
    req = rq(3);
    tick(1, 3, "R8 parked owner yields");
    req = '0; park_mode = 2'd0;
    tick(0, 0, "R9 drop to none");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule